// File: doc/BRIEF.md
# Two-Level Zero-Overhead Loop Controller

This block sits beside the fetch stage of a 32-bit RISC-V core and repeats short code bodies without any branch instructions. A setup instruction arms one of two loop levels. The setup loads three values into that level: a start address, an end address and an iteration count. The controller then watches every valid fetch address. When the address reaches the end of an armed loop that still has passes left, the controller tells fetch to jump back to the loop start and decrements the count.

A setup instruction comes in one of two forms, selected by funct3. In the register form the count is taken from rs1 data. In the immediate form the count is encoded in the instruction itself. In both forms the end address is given as a halfword offset from the setup instruction's own PC, and the loop body starts at the instruction after the setup. Level 0 is the inner loop and is served first when both levels end on the same address. The redirect request is registered, so it appears one clock after the fetch address that caused it.

Top module: `hwloop_ctrl`

## Requirements
- R1: After synchronous reset, both iteration counts are zero and `redir_valid` is 0. No fetch address causes a redirect until a valid setup has been accepted.
- R2: A setup is accepted only when `setup_valid` is 1, instruction bits 6:0 equal 1111011, bits 11:8 are zero and funct3 (bits 14:12) is 100 or 101. Any other instruction leaves both levels unchanged.
- R3: Register form (funct3 100): the count is the `setup_rs1` value and the end offset is the unsigned 12-bit field in bits 31:20. A count of zero leaves the level inactive.
- R4: Immediate form (funct3 101): the count is the unsigned 12-bit field in bits 31:20 and the end offset is the unsigned 5-bit field in bits 19:15.
- R5: Instruction bit 7 picks the level (0 = inner, 1 = outer). The level's start becomes `setup_pc + 4` and its end becomes `setup_pc + 2*offset`.
- R6: A valid fetch whose address equals the end of an active level with count greater than 1 makes `redir_valid` 1 one cycle later, with `redir_target` equal to that level's start. The count drops by one.
- R7: At the end address with count equal to 1, no redirect occurs and the count becomes 0. Further fetches of that address do not redirect.
- R8: When both active levels match the fetch address, only level 0 acts. Level 1 keeps its count and acts on a later match once level 0 is inactive.
- R9: A setup replaces the start, end and count of its target level in the same cycle. The other level's state is not affected.
- R10: When `fetch_valid` is 0 there is no redirect and no count changes. The outputs follow the fetch that caused them by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | A decoded instruction is presented for setup |
| setup_instr | input | 32 | Instruction word of the candidate setup |
| setup_pc | input | AW | PC of the setup instruction |
| setup_rs1 | input | XLEN | rs1 data for the register form |
| fetch_valid | input | 1 | The fetch address is valid this cycle |
| fetch_pc | input | AW | Current fetch address |
| redir_valid | output | 1 | Registered redirect request |
| redir_target | output | AW | Registered redirect address (loop start) |

## Verification
A sweep runs loops of 1 to 6 passes through both levels and both setup forms. The expected redirect pattern is computed from the pass count alone. This separates a correct decrement from an off-by-one exit and a wrong start address. A register-form setup with count zero shows that such a level never redirects. Malformed setups (wrong opcode, nonzero bits 11:8, an unused funct3) are each followed by a fetch of the would-be end address, then by a well-formed setup for contrast. Two further runs cover levels that share an end address and re-arming one level while the other runs; they show inner priority and level isolation. A fetch of the end address with `fetch_valid` low is followed by a valid fetch, which shows the count was not consumed.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int NLVL = 2;
  localparam logic [6:0] OPC_LOOP = 7'b1111011;
  localparam logic [2:0] FN_REG   = 3'b100;
  localparam logic [2:0] FN_IMM   = 3'b101;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_REG  = 2'd1,
    FORM_IMM  = 2'd2
  } setup_form_e;
endpackage

// File: rtl/hwloop_setup_dec.sv
module hwloop_setup_dec
  import hwloop_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int XLEN = 32
) (
  input  logic            setup_valid,
  input  logic [31:0]     setup_instr,
  input  logic [AW-1:0]   setup_pc,
  input  logic [XLEN-1:0] setup_rs1,
  output logic [NLVL-1:0] ld,
  output logic [AW-1:0]   ld_start,
  output logic [AW-1:0]   ld_end,
  output logic [CW-1:0]   ld_cnt
);
  localparam int IMM12_W = 12;
  localparam int IMM5_W  = 5;

  setup_form_e form;
  logic [AW-1:0] off_ext;
  logic          ok;

  always_comb begin
    form = FORM_NONE;
    if (setup_valid && setup_instr[6:0] == OPC_LOOP && setup_instr[11:8] == 4'd0) begin
      if (setup_instr[14:12] == FN_REG)      form = FORM_REG;
      else if (setup_instr[14:12] == FN_IMM) form = FORM_IMM;
    end
  end

  always_comb begin
    off_ext = '0;
    ld_cnt  = '0;
    case (form)
      FORM_REG: begin
        off_ext = AW'({setup_instr[31:20], 1'b0});
        ld_cnt  = setup_rs1[CW-1:0];
      end
      FORM_IMM: begin
        off_ext = AW'({setup_instr[19:15], 1'b0});
        ld_cnt  = {{(CW-IMM12_W){1'b0}}, setup_instr[31:20]};
      end
      default: begin
        off_ext = '0;
        ld_cnt  = '0;
      end
    endcase
  end

  assign ok       = (form != FORM_NONE);
  assign ld_start = setup_pc + AW'(4);
  assign ld_end   = setup_pc + off_ext;

  for (genvar i = 0; i < NLVL; i++) begin : g_ld
    assign ld[i] = ok && (setup_instr[7] == i[0]);
  end

  initial begin
    assert (CW >= IMM12_W && CW <= XLEN && AW > IMM12_W + 1 && IMM5_W < IMM12_W);
  end
endmodule

// File: rtl/hwloop_level.sv
module hwloop_level #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_start,
  input  logic [AW-1:0] ld_end,
  input  logic [CW-1:0] ld_cnt,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          grant,
  output logic          match,
  output logic          take,
  output logic [AW-1:0] start_addr
);
  logic [AW-1:0] start_q, end_q;
  logic [CW-1:0] cnt_q;
  logic          act;

  assign match      = fetch_valid && (cnt_q != '0) && (fetch_pc == end_q);
  assign act        = grant && match;
  assign take       = act && (cnt_q > CW'(1));
  assign start_addr = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
    end else if (ld) begin
      start_q <= ld_start;
      end_q   <= ld_end;
      cnt_q   <= ld_cnt;
    end else if (act) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R9: a setup lands all three registers together
  p_load_all_r9: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_q == $past(ld_cnt)) && (end_q == $past(ld_end)) && (start_q == $past(ld_start)));

  p_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld && grant && match && cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - CW'(1));

  p_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (!ld && grant && match && cnt_q == CW'(1)) |=> cnt_q == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld && !(grant && match)) |=> $stable(cnt_q));
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            setup_valid,
  input  logic [31:0]     setup_instr,
  input  logic [AW-1:0]   setup_pc,
  input  logic [XLEN-1:0] setup_rs1,
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_pc,
  output logic            redir_valid,
  output logic [AW-1:0]   redir_target
);
  logic [NLVL-1:0] ld, match, take, grant;
  logic [AW-1:0]   ld_start, ld_end;
  logic [CW-1:0]   ld_cnt;
  logic [AW-1:0]   start_a [NLVL];
  logic            nxt_valid;
  logic [AW-1:0]   nxt_target;

  hwloop_setup_dec #(.AW(AW), .CW(CW), .XLEN(XLEN)) dec_i (
    .setup_valid(setup_valid),
    .setup_instr(setup_instr),
    .setup_pc   (setup_pc),
    .setup_rs1  (setup_rs1),
    .ld         (ld),
    .ld_start   (ld_start),
    .ld_end     (ld_end),
    .ld_cnt     (ld_cnt)
  );

  // inner level first: each level may act only if no lower index matched
  always_comb begin
    grant[0] = 1'b1;
    for (int i = 1; i < NLVL; i++) grant[i] = grant[i-1] && !match[i-1];
  end

  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    hwloop_level #(.AW(AW), .CW(CW)) lvl_i (
      .clk        (clk),
      .rst        (rst),
      .ld         (ld[i]),
      .ld_start   (ld_start),
      .ld_end     (ld_end),
      .ld_cnt     (ld_cnt),
      .fetch_valid(fetch_valid),
      .fetch_pc   (fetch_pc),
      .grant      (grant[i]),
      .match      (match[i]),
      .take       (take[i]),
      .start_addr (start_a[i])
    );
  end

  always_comb begin
    nxt_valid  = 1'b0;
    nxt_target = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (take[i]) begin
        nxt_valid  = 1'b1;
        nxt_target = nxt_target | start_a[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid  <= 1'b0;
      redir_target <= '0;
    end else begin
      redir_valid  <= nxt_valid;
      redir_target <= nxt_target;
    end
  end

  p_redir_from_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> $past(fetch_valid));

  p_one_taker_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));

  p_no_redir_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (match == '0) |=> !redir_valid);
endmodule

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setup_valid = 1'b0;
  logic [31:0] setup_instr = '0;
  logic [31:0] setup_pc = '0;
  logic [31:0] setup_rs1 = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        redir_valid;
  logic [31:0] redir_target;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwloop_ctrl dut_i (
    .clk(clk), .rst(rst),
    .setup_valid(setup_valid), .setup_instr(setup_instr),
    .setup_pc(setup_pc), .setup_rs1(setup_rs1),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .redir_valid(redir_valid), .redir_target(redir_target)
  );

  function automatic logic [31:0] mk_reg(logic [11:0] off, logic lvl);
    return {off, 5'd1, 3'b100, 4'b0000, lvl, 7'b1111011};
  endfunction

  function automatic logic [31:0] mk_imm(logic [11:0] cnt, logic [4:0] off, logic lvl);
    return {cnt, off, 3'b101, 4'b0000, lvl, 7'b1111011};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(logic [31:0] ins, logic [31:0] pc, logic [31:0] rs1);
    setup_valid = 1'b1; setup_instr = ins; setup_pc = pc; setup_rs1 = rs1;
    @(negedge clk);
    setup_valid = 1'b0;
  endtask

  task automatic fetch(logic [31:0] pc, logic v, logic exp_v, logic [31:0] exp_t, string req);
    fetch_valid = v; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(req, {31'b0, redir_valid}, {31'b0, exp_v});
    if (exp_v) check(req, redir_target, exp_t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset", {31'b0, redir_valid}, 32'd0);
    fetch(32'h0, 1'b1, 1'b0, 32'h0, "R1 idle");
    fetch(32'h1000, 1'b1, 1'b0, 32'h0, "R1 idle");

    // R3 R4 R5 R6 R7: sweep levels, forms, pass counts
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int form = 0; form < 2; form++) begin
        for (int n = 1; n <= 6; n++) begin
          logic [31:0] p = 32'h1000 + 32'((lvl*2 + form) * 256 + n * 4096);
          logic [31:0] e;
          if (form == 0) begin
            setup(mk_reg(12'h010, lvl[0]), p, 32'(n));
            e = p + 32'h20;
          end else begin
            setup(mk_imm(12'(n), 5'h08, lvl[0]), p, 32'hDEAD);
            e = p + 32'h10;
          end
          fetch(p + 4, 1'b1, 1'b0, 0, "R5 body");
          for (int i = 0; i < n; i++)
            fetch(e, 1'b1, (i < n-1), p + 4, form == 0 ? "R3 R6 loop" : "R4 R6 loop");
          fetch(e, 1'b1, 1'b0, 0, "R7 exhausted");
        end
      end
    end
    // R3: count zero stays inactive
    setup(mk_reg(12'h010, 1'b0), 32'h2800, 32'd0);
    fetch(32'h2820, 1'b1, 1'b0, 0, "R3 zero count");

    // R2: malformed setups ignored
    setup(mk_reg(12'h010, 1'b0) ^ 32'h0000_0010, 32'h3000, 32'd3);
    fetch(32'h3020, 1'b1, 1'b0, 0, "R2 opcode");
    setup(mk_reg(12'h010, 1'b0) | 32'h0000_0200, 32'h3000, 32'd3);
    fetch(32'h3020, 1'b1, 1'b0, 0, "R2 bits11to8");
    setup(mk_reg(12'h010, 1'b0) ^ 32'h0000_6000, 32'h3000, 32'd3);
    fetch(32'h3020, 1'b1, 1'b0, 0, "R2 funct3");
    setup(mk_reg(12'h010, 1'b0), 32'h3000, 32'd3);
    fetch(32'h3020, 1'b1, 1'b1, 32'h3004, "R2 accepted");

    // R8: shared end address, inner first
    setup(mk_reg(12'h040, 1'b0), 32'h4000, 32'd3);
    setup(mk_reg(12'h038, 1'b1), 32'h4010, 32'd3);
    fetch(32'h4080, 1'b1, 1'b1, 32'h4004, "R8 inner");
    fetch(32'h4080, 1'b1, 1'b1, 32'h4004, "R8 inner");
    fetch(32'h4080, 1'b1, 1'b0, 0, "R8 inner exit");
    fetch(32'h4080, 1'b1, 1'b1, 32'h4014, "R8 outer");
    fetch(32'h4080, 1'b1, 1'b1, 32'h4014, "R8 outer");
    fetch(32'h4080, 1'b1, 1'b0, 0, "R8 outer exit");

    // R9: re-arm one level, other untouched
    setup(mk_imm(12'd4, 5'h10, 1'b1), 32'h5000, 0);
    setup(mk_imm(12'd5, 5'h04, 1'b0), 32'h6000, 0);
    fetch(32'h5020, 1'b1, 1'b1, 32'h5004, "R9 outer");
    fetch(32'h6008, 1'b1, 1'b1, 32'h6004, "R9 inner");
    setup(mk_imm(12'd2, 5'h02, 1'b1), 32'h7000, 0);
    fetch(32'h5020, 1'b1, 1'b0, 0, "R9 old end gone");
    fetch(32'h7004, 1'b1, 1'b1, 32'h7004, "R9 new end");
    fetch(32'h6008, 1'b1, 1'b1, 32'h6004, "R9 inner kept");

    // R10: invalid fetch consumes nothing
    fetch(32'h6008, 1'b0, 1'b0, 0, "R10 no fetch");
    fetch(32'h6008, 1'b1, 1'b1, 32'h6004, "R10 count kept");
    fetch(32'h6008, 1'b1, 1'b1, 32'h6004, "R10 count kept");
    fetch(32'h6008, 1'b1, 1'b0, 0, "R10 exit");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule